// File: doc/BRIEF.md
# Miss-Distance Branch Confidence Estimator

This block tells the front end whether the prediction for a conditional branch deserves trust. When it reports low confidence, the branch region is run down both paths under predication instead of being speculated. For each of two component predictors (one indexed by global history, one indexed by branch address) it keeps a table of small counters. Each counter measures how many correct predictions have been seen at its index since the last misprediction.

A lookup presents one index for each table and the chooser's pick of component. The counter from the picked table is compared against a fixed threshold, and a value below the threshold raises the low-confidence flag. A second lookup mode reads no table at all. It reports high confidence only when the two component predictors' own direction counters, supplied with the lookup, both sit at the same extreme. An update presents one index for each table and a separate correct or incorrect verdict for each component.

Top module: `conf_est`

## Requirements
- R1: After reset every counter in both tables is zero, so a lookup in counter mode (lkAltMode=0) reports lkLowConf=1 for every index.
- R2: An update with updValid=1 and a correct verdict for a table adds one to that table's counter at its update index. The change is visible from the next clock.
- R3: An update with updValid=1 and an incorrect verdict for a table sets that table's counter at its update index to zero.
- R4: In counter mode, lkLowConf is 1 when the selected counter is below THRESH (default 7) and 0 when it is at or above THRESH.
- R5: A counter at its maximum (15 for the default 4-bit width) stays at the maximum on further correct verdicts and never wraps.
- R6: In counter mode, lkUseGlobal=1 takes the counter from the global-history table at lkGIdx, and lkUseGlobal=0 takes it from the per-address table at lkLIdx.
- R7: With lkAltMode=1, lkLowConf is 0 exactly when lkGPredCtr and lkLPredCtr are both all ones or both zero, and 1 otherwise, whatever the counter tables hold.
- R8: A lookup in the same cycle as an update to the same index sees the value held before that update.
- R9: With updValid=0 no counter changes, whatever the verdict and index inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkGIdx | input | G_IDX_W | Lookup index into the global-history table |
| lkLIdx | input | L_IDX_W | Lookup index into the per-address table |
| lkUseGlobal | input | 1 | Chooser pick: 1 selects the global table, 0 the per-address table |
| lkAltMode | input | 1 | 1 selects the saturation-agreement mode |
| lkGPredCtr | input | PCTR_W | Direction counter of the global component predictor |
| lkLPredCtr | input | PCTR_W | Direction counter of the per-address component predictor |
| lkLowConf | output | 1 | 1 when confidence is low |
| updValid | input | 1 | Update strobe |
| updGIdx | input | G_IDX_W | Update index into the global-history table |
| updLIdx | input | L_IDX_W | Update index into the per-address table |
| updGCorrect | input | 1 | 1 if the global component predicted correctly |
| updLCorrect | input | 1 | 1 if the per-address component predicted correctly |

## Verification
A lookup and an update can arrive in the same cycle and at the same index. The lookup must then report the counter value from before the update, while the update takes effect at the clock edge. The bench provokes this by steering both ports at the same index, both in directed sequences that cross the threshold and in a random phase that draws indices from a small range so collisions happen often. A behavioural model checks lkLowConf on every cycle. The model commits its own update only after it has compared the result for that cycle.

// File: rtl/conf_est_pkg.sv
package conf_est_pkg;

  // Per-table write strobes from control to datapath
  typedef struct packed {
    logic gBump;
    logic gZero;
    logic lBump;
    logic lZero;
  } tblStrobe_t;

endpackage

// File: rtl/conf_tbl.sv
module conf_tbl #(
  parameter int IDX_W = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bump,
  input  logic             zero,
  input  logic [IDX_W-1:0] wIdx,
  input  logic [IDX_W-1:0] rIdx,
  output logic [CNT_W-1:0] rdCnt
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cells [DEPTH];

  // Read returns the value held before any write in this cycle
  assign rdCnt = cells[rIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (zero) begin
      cells[wIdx] <= '0;
    end else if (bump && cells[wIdx] != CNT_MAX) begin
      cells[wIdx] <= cells[wIdx] + 1'b1;
    end
  end
endmodule

// File: rtl/conf_dp.sv
module conf_dp
  import conf_est_pkg::*;
#(
  parameter int G_IDX_W = 6,
  parameter int L_IDX_W = 6,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  tblStrobe_t         strobe,
  input  logic [G_IDX_W-1:0] updGIdx,
  input  logic [L_IDX_W-1:0] updLIdx,
  input  logic [G_IDX_W-1:0] lkGIdx,
  input  logic [L_IDX_W-1:0] lkLIdx,
  output logic [CNT_W-1:0]   gCnt,
  output logic [CNT_W-1:0]   lCnt
);
  localparam int N_TBL = 2;

  generate
    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
      if (t == 0) begin : g_glob
        conf_tbl #(.IDX_W(G_IDX_W), .CNT_W(CNT_W)) u_tbl (
          .clk   (clk),
          .rstN  (rstN),
          .bump  (strobe.gBump),
          .zero  (strobe.gZero),
          .wIdx  (updGIdx),
          .rIdx  (lkGIdx),
          .rdCnt (gCnt)
        );
      end else begin : g_addr
        conf_tbl #(.IDX_W(L_IDX_W), .CNT_W(CNT_W)) u_tbl (
          .clk   (clk),
          .rstN  (rstN),
          .bump  (strobe.lBump),
          .zero  (strobe.lZero),
          .wIdx  (updLIdx),
          .rIdx  (lkLIdx),
          .rdCnt (lCnt)
        );
      end
    end
  endgenerate
endmodule

// File: rtl/conf_ctrl.sv
module conf_ctrl
  import conf_est_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int PCTR_W = 2,
  parameter int THRESH = 7
) (
  input  logic              updValid,
  input  logic              updGCorrect,
  input  logic              updLCorrect,
  input  logic              lkUseGlobal,
  input  logic              lkAltMode,
  input  logic [PCTR_W-1:0] lkGPredCtr,
  input  logic [PCTR_W-1:0] lkLPredCtr,
  input  logic [CNT_W-1:0]  gCnt,
  input  logic [CNT_W-1:0]  lCnt,
  output tblStrobe_t        strobe,
  output logic              lkLowConf
);
  localparam logic [CNT_W-1:0]  THR      = CNT_W'(THRESH);
  localparam logic [PCTR_W-1:0] PCTR_TOP = '1;

  logic [CNT_W-1:0] selCnt;
  logic bothTop, bothBottom;

  always_comb begin
    strobe.gBump = updValid &  updGCorrect;
    strobe.gZero = updValid & ~updGCorrect;
    strobe.lBump = updValid &  updLCorrect;
    strobe.lZero = updValid & ~updLCorrect;
  end

  assign selCnt     = lkUseGlobal ? gCnt : lCnt;
  assign bothTop    = (lkGPredCtr == PCTR_TOP) && (lkLPredCtr == PCTR_TOP);
  assign bothBottom = (lkGPredCtr == '0) && (lkLPredCtr == '0);

  always_comb begin
    if (lkAltMode) lkLowConf = !(bothTop || bothBottom);
    else           lkLowConf = (selCnt < THR);
  end
endmodule

// File: rtl/conf_est.sv
module conf_est
  import conf_est_pkg::*;
#(
  parameter int G_IDX_W = 6,
  parameter int L_IDX_W = 6,
  parameter int CNT_W   = 4,
  parameter int PCTR_W  = 2,
  parameter int THRESH  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [G_IDX_W-1:0] lkGIdx,
  input  logic [L_IDX_W-1:0] lkLIdx,
  input  logic               lkUseGlobal,
  input  logic               lkAltMode,
  input  logic [PCTR_W-1:0]  lkGPredCtr,
  input  logic [PCTR_W-1:0]  lkLPredCtr,
  output logic               lkLowConf,
  input  logic               updValid,
  input  logic [G_IDX_W-1:0] updGIdx,
  input  logic [L_IDX_W-1:0] updLIdx,
  input  logic               updGCorrect,
  input  logic               updLCorrect
);
  tblStrobe_t       strobe;
  logic [CNT_W-1:0] gCnt, lCnt;

  conf_ctrl #(.CNT_W(CNT_W), .PCTR_W(PCTR_W), .THRESH(THRESH)) u_ctrl (
    .updValid    (updValid),
    .updGCorrect (updGCorrect),
    .updLCorrect (updLCorrect),
    .lkUseGlobal (lkUseGlobal),
    .lkAltMode   (lkAltMode),
    .lkGPredCtr  (lkGPredCtr),
    .lkLPredCtr  (lkLPredCtr),
    .gCnt        (gCnt),
    .lCnt        (lCnt),
    .strobe      (strobe),
    .lkLowConf   (lkLowConf)
  );

  conf_dp #(.G_IDX_W(G_IDX_W), .L_IDX_W(L_IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .updGIdx (updGIdx),
    .updLIdx (updLIdx),
    .lkGIdx  (lkGIdx),
    .lkLIdx  (lkLIdx),
    .gCnt    (gCnt),
    .lCnt    (lCnt)
  );
endmodule

// File: rtl/conf_est_chk.sv
module conf_est_chk #(
  parameter int G_IDX_W = 6,
  parameter int L_IDX_W = 6,
  parameter int PCTR_W  = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [G_IDX_W-1:0] lkGIdx,
  input logic [L_IDX_W-1:0] lkLIdx,
  input logic               lkUseGlobal,
  input logic               lkAltMode,
  input logic [PCTR_W-1:0]  lkGPredCtr,
  input logic [PCTR_W-1:0]  lkLPredCtr,
  input logic               lkLowConf,
  input logic               updValid,
  input logic [G_IDX_W-1:0] updGIdx,
  input logic [L_IDX_W-1:0] updLIdx,
  input logic               updGCorrect,
  input logic               updLCorrect
);
  localparam logic [PCTR_W-1:0] TOP = '1;

  // R7
  alt_agree_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkAltMode && ((lkGPredCtr == TOP && lkLPredCtr == TOP) ||
                   (lkGPredCtr == '0 && lkLPredCtr == '0))) |-> !lkLowConf);

  // R7
  alt_disagree_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkAltMode && (lkGPredCtr != lkLPredCtr)) |-> lkLowConf);

  // R3
  glob_miss_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updGCorrect) |=>
      (!(!lkAltMode && lkUseGlobal && lkGIdx == $past(updGIdx)) || lkLowConf));

  // R3
  addr_miss_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updLCorrect) |=>
      (!(!lkAltMode && !lkUseGlobal && lkLIdx == $past(updLIdx)) || lkLowConf));

  // R1
  reset_low_chk: assert property (@(posedge clk)
    (!rstN && !lkAltMode) |=> (!rstN || lkAltMode || lkLowConf));
endmodule

bind conf_est conf_est_chk #(
  .G_IDX_W(G_IDX_W), .L_IDX_W(L_IDX_W), .PCTR_W(PCTR_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .lkGIdx      (lkGIdx),
  .lkLIdx      (lkLIdx),
  .lkUseGlobal (lkUseGlobal),
  .lkAltMode   (lkAltMode),
  .lkGPredCtr  (lkGPredCtr),
  .lkLPredCtr  (lkLPredCtr),
  .lkLowConf   (lkLowConf),
  .updValid    (updValid),
  .updGIdx     (updGIdx),
  .updLIdx     (updLIdx),
  .updGCorrect (updGCorrect),
  .updLCorrect (updLCorrect)
);

// File: tb/tb_conf_est.sv
module tb_conf_est;
  localparam int CLK_PERIOD = 10;
  localparam int GW = 6;
  localparam int LW = 6;
  localparam int GD = 1 << GW;
  localparam int LD = 1 << LW;
  localparam int SAT = 15;
  localparam int THR = 7;

  logic clk = 0;
  logic rstN;
  logic [GW-1:0] lkGIdx, updGIdx;
  logic [LW-1:0] lkLIdx, updLIdx;
  logic lkUseGlobal, lkAltMode, updValid, updGCorrect, updLCorrect;
  logic [1:0] lkGPredCtr, lkLPredCtr;
  logic lkLowConf;

  int gRef [GD];
  int lRef [LD];
  int checks = 0;
  int failures = 0;

  conf_est dut (
    .clk(clk), .rstN(rstN), .lkGIdx(lkGIdx), .lkLIdx(lkLIdx),
    .lkUseGlobal(lkUseGlobal), .lkAltMode(lkAltMode),
    .lkGPredCtr(lkGPredCtr), .lkLPredCtr(lkLPredCtr), .lkLowConf(lkLowConf),
    .updValid(updValid), .updGIdx(updGIdx), .updLIdx(updLIdx),
    .updGCorrect(updGCorrect), .updLCorrect(updLCorrect)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic expLow();
    int c;
    if (lkAltMode)
      return !((lkGPredCtr == 2'd3 && lkLPredCtr == 2'd3) ||
               (lkGPredCtr == 2'd0 && lkLPredCtr == 2'd0));
    c = lkUseGlobal ? gRef[lkGIdx] : lRef[lkLIdx];
    return c < THR;
  endfunction

  // Compare this cycle, then let the model follow the clock edge
  task automatic step(input string tag);
    logic e;
    #1;
    e = expLow();
    checks++;
    if (lkLowConf !== e) begin
      failures++;
      $display("FAIL %s: lkLowConf actual=%b expected=%b at %0t", tag, lkLowConf, e, $time);
    end
    @(posedge clk);
    if (!rstN) begin
      for (int i = 0; i < GD; i++) gRef[i] = 0;
      for (int i = 0; i < LD; i++) lRef[i] = 0;
    end else if (updValid) begin
      if (updGCorrect) begin if (gRef[updGIdx] < SAT) gRef[updGIdx]++; end
      else gRef[updGIdx] = 0;
      if (updLCorrect) begin if (lRef[updLIdx] < SAT) lRef[updLIdx]++; end
      else lRef[updLIdx] = 0;
    end
    @(negedge clk);
  endtask

  task automatic look(input int gi, input int li, input logic useG);
    lkGIdx = GW'(gi); lkLIdx = LW'(li); lkUseGlobal = useG; lkAltMode = 0;
  endtask

  task automatic upd(input logic v, input int gi, input int li, input logic gc, input logic lc);
    updValid = v; updGIdx = GW'(gi); updLIdx = LW'(li); updGCorrect = gc; updLCorrect = lc;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < GD; i++) gRef[i] = 0;
    for (int i = 0; i < LD; i++) lRef[i] = 0;
    rstN = 0; lkGPredCtr = 0; lkLPredCtr = 1;
    look(0, 0, 1); upd(0, 0, 0, 0, 0);
    @(negedge clk);
    for (int i = 0; i < 3; i++) step("R1 in reset");
    rstN = 1;
    // R1: every index reads low after reset
    for (int i = 0; i < 8; i++) begin look(i * 9, i * 7, i[0]); step("R1 after reset"); end

    // R2/R4/R8: bump global 5 and local 9, lookup on the same index in the same cycle
    look(5, 9, 1);
    for (int i = 0; i < 7; i++) begin upd(1, 5, 9, 1, 1); step("R8 R2 same-cycle bump"); end
    upd(0, 5, 9, 0, 0); step("R4 at threshold global high");
    look(5, 9, 0); step("R6 local table also at threshold");
    // R4 below threshold on another index: 6 corrects
    look(12, 12, 1);
    for (int i = 0; i < 6; i++) begin upd(1, 12, 12, 1, 0); step("R2 bump below threshold"); end
    upd(0, 0, 0, 0, 0); step("R4 six is below threshold");
    look(12, 12, 0); step("R6 local reads its own cleared entry");
    // R5: saturation, no wrap after many corrects
    look(5, 9, 1);
    for (int i = 0; i < 20; i++) begin upd(1, 5, 9, 1, 0); step("R5 saturating run"); end
    upd(0, 0, 0, 0, 0); step("R5 still high at max");
    look(5, 9, 0); step("R3 local index cleared by miss");
    // R9: no update when updValid is low
    look(5, 9, 1);
    for (int i = 0; i < 4; i++) begin upd(0, 5, 9, 0, 0); step("R9 idle miss ignored"); end
    // R3: miss on global clears
    upd(1, 5, 9, 0, 1); step("R8 pre-miss value seen");
    upd(0, 0, 0, 0, 0); step("R3 global miss cleared");
    // R7: alternative mode patterns, counters irrelevant
    lkAltMode = 1;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        lkGPredCtr = 2'(a); lkLPredCtr = 2'(b); step("R7 agreement mode");
      end
    // Random phase with small index ranges to force collisions
    for (int n = 0; n < 3000; n++) begin
      lkGIdx = GW'($urandom_range(0, 3)); lkLIdx = LW'($urandom_range(0, 3));
      lkUseGlobal = 1'($urandom_range(0, 1));
      lkAltMode = ($urandom_range(0, 7) == 0);
      lkGPredCtr = 2'($urandom_range(0, 3)); lkLPredCtr = 2'($urandom_range(0, 3));
      updValid = ($urandom_range(0, 3) != 0);
      updGIdx = ($urandom_range(0, 1) == 1) ? lkGIdx : GW'($urandom_range(0, 3));
      updLIdx = ($urandom_range(0, 1) == 1) ? lkLIdx : LW'($urandom_range(0, 3));
      updGCorrect = ($urandom_range(0, 11) != 0);
      updLCorrect = ($urandom_range(0, 11) != 0);
      step("R8 random collision mix");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule